// File: doc/BRIEF.md
# Indexed-Access Real-Time Clock Core

A synthesizable time-of-day and calendar counter with a daily alarm, an interrupt output and a block of general-purpose byte storage. A host reaches all of it through a two-location port. A write to location 0 latches an index into a 64-byte map. Location 1 then reads or writes the byte at that index. The latched index stays in force until location 0 is written again. The time registers advance once per second. The second is derived from a 32.768 kHz clock enable by a divider, and the number of enables per second is a parameter.

Before each once-per-second register update, the core raises an update-in-progress flag for a fixed number of enables, and holds it for a fixed window in total. Software polls this flag so that it never reads a half-updated time. Two control bits stop the clock: one holds the divider cleared, and the other inhibits register updates while software loads a new time. All data is binary. Hours run either 0 to 23 or 1 to 12 with a PM flag.

Top module: `rtc_indexed_core`

## Requirements
- R1: A write to port location 0 latches wdata_i[5:0] as the index, and bits 7:6 are ignored. Every read or write at location 1 acts on the last latched index, including repeated accesses without a new index write.
- R2: Indices 14 to 63 are byte storage that the host writes and reads back unchanged.
- R3: On each update, the seconds (index 0) and minutes (index 2) count 0 to 59. Day of week (index 6) counts 1 to 7 and then returns to 1. Day of month (index 7) counts from 1 to the month length (30 for months 4, 6, 9 and 11, 31 for the others). February has 29 days when year[1:0] is 0 and 28 days otherwise. Month (index 8) counts 1 to 12, and year (index 9) counts 0 to 99 and then returns to 0.
- R4: With register B (index 11) bit 1 set, hours (index 4) count 0 to 23, and the step from 23 to 0 advances the date.
- R5: With register B bit 1 clear, hours hold 1 to 12 with bit 7 as PM. 11 AM goes to 12 PM (0x8C), 12 goes to 1 with the same PM bit, and 11 PM goes to 12 AM (0x0C) and advances the date.
- R6: Register A (index 10) bit 7 reads the update-in-progress flag. It rises LEAD_TICKS enables before the time registers change and stays high for UIP_TICKS enables in total. A host write to bit 7 is ignored.
- R7: Register A bits 6:4 equal to 010 (for example, the value 0x20) let the divider run. Any other value (for example, 0x60) holds the divider cleared, so no update occurs and bit 7 reads 0. Bits 6:0 read back as written.
- R8: Register B bit 7 set blocks every update, and register A bit 7 reads 0 while it is set.
- R9: On each update, register C (index 12) bit 4 is set. Bit 5 is set as well when the new seconds, minutes and hours equal indices 1, 3 and 5.
- R10: Register C bit 7 is (bit5 AND B bit5) OR (bit4 AND B bit4), and irq_no is its inverse.
- R11: A read of register C returns the flags and clears them, which releases irq_no. A flag raised in the same cycle as the read is kept. Writes to register C are ignored.
- R12: Register D (index 13) always reads 0x80, and writes to it are ignored.
- R13: After reset, the index is 0 and the time reads 00:00:00, day of week 1, date 1/1, year 0. Register A is 0x20, register B is 0x02, register C is 0 and irq_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz clock enable |
| sel_i | input | 1 | Host access strobe, one cycle per access |
| addr_i | input | 1 | Port location: 0 = index, 1 = data |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Byte at the latched index |
| irq_no | output | 1 | Active-low interrupt |

## Verification
The hardest event to reach is a single update that lands on a chosen calendar boundary, such as the last second of a leap-year February or the 11:59:59 PM hour roll. It is also hard to sample that update at a known moment relative to the update-in-progress window. For each table entry, the bench loads the start time with updates inhibited and the divider held, and then releases both. It finds the one following update by polling register A bit 7 through the port, first until the bit rises and then until it falls. The bench reads the seconds at the moment it first sees the flag high, which shows that the lead time comes before the change. The number of polls the flag stays high is checked against the window length.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned MAP_BYTES = 1 << IDX_W;
  localparam int unsigned RAM_BASE  = 14;

  localparam logic [IDX_W-1:0] IX_SEC  = 6'd0;
  localparam logic [IDX_W-1:0] IX_ASEC = 6'd1;
  localparam logic [IDX_W-1:0] IX_MIN  = 6'd2;
  localparam logic [IDX_W-1:0] IX_AMIN = 6'd3;
  localparam logic [IDX_W-1:0] IX_HR   = 6'd4;
  localparam logic [IDX_W-1:0] IX_AHR  = 6'd5;
  localparam logic [IDX_W-1:0] IX_DOW  = 6'd6;
  localparam logic [IDX_W-1:0] IX_DOM  = 6'd7;
  localparam logic [IDX_W-1:0] IX_MON  = 6'd8;
  localparam logic [IDX_W-1:0] IX_YR   = 6'd9;
  localparam logic [IDX_W-1:0] IX_CTLA = 6'd10;
  localparam logic [IDX_W-1:0] IX_CTLB = 6'd11;
  localparam logic [IDX_W-1:0] IX_CTLC = 6'd12;
  localparam logic [IDX_W-1:0] IX_CTLD = 6'd13;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: month_len = 8'd30;
      8'd2:                    month_len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 month_len = 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned LEAD_TICKS    = 8,
  parameter int unsigned UIP_TICKS     = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  output logic upd_o,
  output logic uip_o
);
  localparam int unsigned CW = $clog2(TICKS_PER_SEC);
  localparam int unsigned TW = $clog2(UIP_TICKS + 1);
  localparam logic [CW-1:0] LAST  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] START = CW'(TICKS_PER_SEC - LEAD_TICKS);
  localparam logic [TW-1:0] TAIL  = TW'(UIP_TICKS - LEAD_TICKS);

  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tail_q;
  logic          wrap;

  assign wrap  = run_i && tick_i && (cnt_q == LAST);
  assign upd_o = wrap;
  // window: lead part before the wrap, remainder counted down after it
  assign uip_o = run_i && ((cnt_q >= START) || (tail_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tail_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tail_q <= '0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)               tail_q <= TAIL;
      else if (tail_q != '0)  tail_q <= tail_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             h24_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output rtc_time_t        time_o,
  output rtc_time_t        next_o
);
  rtc_time_t cur_q, nxt, cur_d;
  logic      roll_day;

  always_comb begin
    nxt      = cur_q;
    roll_day = 1'b0;
    if (cur_q.sec >= 8'd59) begin
      nxt.sec = '0;
      if (cur_q.min >= 8'd59) begin
        nxt.min = '0;
        if (h24_i) begin
          if (cur_q.hr >= 8'd23) begin
            nxt.hr   = '0;
            roll_day = 1'b1;
          end else begin
            nxt.hr = cur_q.hr + 8'd1;
          end
        end else if (cur_q.hr[6:0] == 7'd11) begin
          nxt.hr   = cur_q.hr[7] ? 8'h0C : 8'h8C;
          roll_day = cur_q.hr[7];
        end else if (cur_q.hr[6:0] >= 7'd12) begin
          nxt.hr = {cur_q.hr[7], 7'd1};
        end else begin
          nxt.hr = {cur_q.hr[7], cur_q.hr[6:0] + 7'd1};
        end
      end else begin
        nxt.min = cur_q.min + 8'd1;
      end
    end else begin
      nxt.sec = cur_q.sec + 8'd1;
    end

    if (roll_day) begin
      nxt.dow = (cur_q.dow >= 8'd7) ? 8'd1 : cur_q.dow + 8'd1;
      if (cur_q.dom >= month_len(cur_q.mon, cur_q.yr)) begin
        nxt.dom = 8'd1;
        if (cur_q.mon >= 8'd12) begin
          nxt.mon = 8'd1;
          nxt.yr  = (cur_q.yr >= 8'd99) ? 8'd0 : cur_q.yr + 8'd1;
        end else begin
          nxt.mon = cur_q.mon + 8'd1;
        end
      end else begin
        nxt.dom = cur_q.dom + 8'd1;
      end
    end
  end

  // host write wins over the step for the field it touches
  always_comb begin
    cur_d = step_i ? nxt : cur_q;
    if (wr_i) begin
      case (idx_i)
        IX_SEC:  cur_d.sec = wdata_i;
        IX_MIN:  cur_d.min = wdata_i;
        IX_HR:   cur_d.hr  = wdata_i;
        IX_DOW:  cur_d.dow = wdata_i;
        IX_DOM:  cur_d.dom = wdata_i;
        IX_MON:  cur_d.mon = wdata_i;
        IX_YR:   cur_d.yr  = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '{sec: 8'd0, min: 8'd0, hr: 8'd0, dow: 8'd1,
                           dom: 8'd1, mon: 8'd1, yr: 8'd0};
    else         cur_q <= cur_d;
  end

  assign time_o = cur_q;
  assign next_o = nxt;
endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
  parameter int unsigned DEPTH = 50,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];
  logic       in_range;

  assign in_range = 32'(addr_i) < DEPTH;
  assign rdata_o  = in_range ? mem_q[addr_i] : 8'h00;

  // contents survive reset, as battery-held storage would
  always_ff @(posedge clk_i) begin
    if (we_i && in_range) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/rtc_indexed_core.sv
module rtc_indexed_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned LEAD_TICKS    = 8,
  parameter int unsigned UIP_TICKS     = 65
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       sel_i,
  input  logic       addr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_no
);
  localparam int unsigned RAM_BYTES = MAP_BYTES - RAM_BASE;
  localparam int unsigned RAM_AW    = $clog2(RAM_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic [6:0]       ctl_a_q;
  logic [7:0]       ctl_b_q;
  logic [7:0]       al_sec_q, al_min_q, al_hr_q;
  logic             af_q, uf_q;

  logic             wr_idx, wr_dat, rd_dat, rd_c;
  logic             run, set_bit, upd, uip_raw, uip, step, match, irqf;
  rtc_time_t        cur_t, next_t;
  logic [IDX_W-1:0] ram_off;
  logic [7:0]       ram_rdata;

  assign wr_idx  = sel_i && !addr_i && we_i;
  assign wr_dat  = sel_i && addr_i && we_i;
  assign rd_dat  = sel_i && addr_i && !we_i;
  assign rd_c    = rd_dat && (idx_q == IX_CTLC);

  assign run     = (ctl_a_q[6:4] == 3'b010);
  assign set_bit = ctl_b_q[7];
  assign step    = upd && !set_bit;
  assign uip     = uip_raw && !set_bit;
  assign match   = (next_t.sec == al_sec_q) && (next_t.min == al_min_q) &&
                   (next_t.hr == al_hr_q);
  assign irqf    = (af_q && ctl_b_q[5]) || (uf_q && ctl_b_q[4]);
  assign irq_no  = !irqf;

  rtc_divider #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .LEAD_TICKS   (LEAD_TICKS),
    .UIP_TICKS    (UIP_TICKS)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .run_i (run),
    .upd_o (upd),
    .uip_o (uip_raw)
  );

  rtc_calendar u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .h24_i  (ctl_b_q[1]),
    .wr_i   (wr_dat),
    .idx_i  (idx_q),
    .wdata_i(wdata_i),
    .time_o (cur_t),
    .next_o (next_t)
  );

  assign ram_off = idx_q - IDX_W'(RAM_BASE);

  rtc_scratch_ram #(.DEPTH(RAM_BYTES)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_dat && (idx_q >= IDX_W'(RAM_BASE))),
    .addr_i (ram_off[RAM_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      ctl_a_q  <= 7'h20;
      ctl_b_q  <= 8'h02;
      al_sec_q <= '0;
      al_min_q <= '0;
      al_hr_q  <= '0;
      af_q     <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      if (wr_idx) idx_q <= wdata_i[IDX_W-1:0];
      if (wr_dat) begin
        case (idx_q)
          IX_ASEC: al_sec_q <= wdata_i;
          IX_AMIN: al_min_q <= wdata_i;
          IX_AHR:  al_hr_q  <= wdata_i;
          IX_CTLA: ctl_a_q  <= wdata_i[6:0];
          IX_CTLB: ctl_b_q  <= wdata_i;
          default: ;
        endcase
      end
      // a flag raised in the reading cycle survives the clear
      af_q <= (af_q && !rd_c) || (step && match);
      uf_q <= (uf_q && !rd_c) || step;
    end
  end

  always_comb begin
    case (idx_q)
      IX_SEC:  rdata_o = cur_t.sec;
      IX_ASEC: rdata_o = al_sec_q;
      IX_MIN:  rdata_o = cur_t.min;
      IX_AMIN: rdata_o = al_min_q;
      IX_HR:   rdata_o = cur_t.hr;
      IX_AHR:  rdata_o = al_hr_q;
      IX_DOW:  rdata_o = cur_t.dow;
      IX_DOM:  rdata_o = cur_t.dom;
      IX_MON:  rdata_o = cur_t.mon;
      IX_YR:   rdata_o = cur_t.yr;
      IX_CTLA: rdata_o = {uip, ctl_a_q};
      IX_CTLB: rdata_o = ctl_b_q;
      IX_CTLC: rdata_o = {irqf, 1'b0, af_q, uf_q, 4'b0000};
      IX_CTLD: rdata_o = 8'h80;
      default: rdata_o = ram_rdata;
    endcase
  end
endmodule

// File: rtl/rtc_indexed_core_chk.sv
module rtc_indexed_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       addr_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic       irq_no,
  input logic [5:0] idx_i,
  input logic [7:0] sec_i,
  input logic       uip_i,
  input logic       run_i,
  input logic       set_i,
  input logic       step_i,
  input logic       af_i,
  input logic       uf_i
);
  logic wr_sec, wr_b, rd_c;
  assign wr_sec = sel_i && addr_i && we_i && (idx_i == 6'd0);
  assign wr_b   = sel_i && addr_i && we_i && (idx_i == 6'd11);
  assign rd_c   = sel_i && addr_i && !we_i && (idx_i == 6'd12);

  // R1
  idx_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !addr_i && we_i) |=> (idx_i == $past(wdata_i[5:0])));

  // R6
  uip_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sec_i) && !$past(wr_sec)) |-> $past(uip_i));

  // R7
  halt_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_sec) |=> $stable(sec_i));

  // R8
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !wr_sec) |=> $stable(sec_i));

  // R11
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && !step_i) |=> (!af_i && !uf_i));

  // R10
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> ($past(step_i) || $past(wr_b)));
endmodule

bind rtc_indexed_core rtc_indexed_core_chk chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .irq_no (irq_no),
  .idx_i  (idx_q),
  .sec_i  (cur_t.sec),
  .uip_i  (uip),
  .run_i  (run),
  .set_i  (set_bit),
  .step_i (step),
  .af_i   (af_q),
  .uf_i   (uf_q)
);

// File: tb/rtc_indexed_core_tb_top.sv
module rtc_indexed_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 128;
  localparam int LEAD       = 8;
  localparam int WIN        = 65;
  localparam int WDOG       = 100000;

  typedef struct packed {
    logic       h24;
    logic [7:0] s, m, h, dw, dm, mo, yr;
    logic [7:0] es, em, eh, edw, edm, emo, eyr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd23, 8'd50, 8'd10, 8'd5, 8'd8,  8'd5,  8'd97, 8'd24, 8'd50, 8'd10, 8'd5, 8'd8,  8'd5,  8'd97},
    '{1'b1, 8'd59, 8'd59, 8'd23, 8'd7, 8'd31, 8'd12, 8'd99, 8'd0,  8'd0,  8'd0,  8'd1, 8'd1,  8'd1,  8'd0},
    '{1'b1, 8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2,  8'd96, 8'd0,  8'd0,  8'd0,  8'd4, 8'd29, 8'd2,  8'd96},
    '{1'b1, 8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2,  8'd97, 8'd0,  8'd0,  8'd0,  8'd4, 8'd1,  8'd3,  8'd97},
    '{1'b1, 8'd59, 8'd59, 8'd23, 8'd2, 8'd30, 8'd4,  8'd97, 8'd0,  8'd0,  8'd0,  8'd3, 8'd1,  8'd5,  8'd97},
    '{1'b0, 8'd59, 8'd59, 8'h8B, 8'd2, 8'd15, 8'd6,  8'd50, 8'd0,  8'd0,  8'h0C, 8'd3, 8'd16, 8'd6,  8'd50},
    '{1'b0, 8'd59, 8'd59, 8'h0B, 8'd2, 8'd15, 8'd6,  8'd50, 8'd0,  8'd0,  8'h8C, 8'd2, 8'd15, 8'd6,  8'd50},
    '{1'b0, 8'd59, 8'd59, 8'h8C, 8'd2, 8'd15, 8'd6,  8'd50, 8'd0,  8'd0,  8'h81, 8'd2, 8'd15, 8'd6,  8'd50},
    '{1'b0, 8'd59, 8'd59, 8'h0C, 8'd2, 8'd15, 8'd6,  8'd50, 8'd0,  8'd0,  8'h01, 8'd2, 8'd15, 8'd6,  8'd50},
    '{1'b1, 8'd59, 8'd59, 8'd13, 8'd4, 8'd10, 8'd10, 8'd10, 8'd0,  8'd0,  8'd14, 8'd4, 8'd10, 8'd10, 8'd10},
    '{1'b1, 8'd59, 8'd59, 8'd23, 8'd4, 8'd29, 8'd2,  8'd96, 8'd0,  8'd0,  8'd0,  8'd5, 8'd1,  8'd3,  8'd96},
    '{1'b1, 8'd59, 8'd30, 8'd9,  8'd1, 8'd31, 8'd1,  8'd0,  8'd0,  8'd31, 8'd9,  8'd1, 8'd31, 8'd1,  8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       sel = 1'b0, addr = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  logic [7:0] rd_q;
  int         checks = 0;
  int         fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_indexed_core #(
    .TICKS_PER_SEC(TPS),
    .LEAD_TICKS   (LEAD),
    .UIP_TICKS    (WIN)
  ) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .tick_i (tick),
    .sel_i  (sel),
    .addr_i (addr),
    .we_i   (we),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_no (irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic op(input logic a, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; addr = a; we = w; wdata = d;
    #2 rd_q = rdata;
    @(posedge clk);
    #1 sel = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    op(1'b0, 1'b1, i);
    op(1'b1, 1'b1, d);
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] v);
    op(1'b0, 1'b1, i);
    op(1'b1, 1'b0, 8'h00);
    v = rd_q;
  endtask

  task automatic load(input logic [7:0] mode, input logic [7:0] s, m, h, dw, dm, mo, yr,
                      input logic [7:0] as, am, ah);
    wr(8'd11, 8'h80 | mode);
    wr(8'd10, 8'h60);
    wr(8'd0, s);  wr(8'd2, m);  wr(8'd4, h);
    wr(8'd6, dw); wr(8'd7, dm); wr(8'd8, mo); wr(8'd9, yr);
    wr(8'd1, as); wr(8'd3, am); wr(8'd5, ah);
    wr(8'd10, 8'h20);
    wr(8'd11, mode);
  endtask

  // polls flag up then down; returns number of polls seen high
  task automatic wait_update(output int hi_polls);
    logic [7:0] v;
    int guard;
    hi_polls = 0;
    guard = 0;
    v = 8'h00;
    while (!v[7] && guard < 1000) begin rd(8'd10, v); guard++; end
    while (v[7] && guard < 1000) begin rd(8'd10, v); hi_polls++; guard++; end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int hp;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R13 reset state
    @(negedge clk);
    chk("R13 irq_no", {7'd0, irq_n}, 8'd1);
    chk("R13 index0 seconds", rdata, 8'd0);
    rd(8'd10, v); chk("R13 reg A", v, 8'h20);
    rd(8'd4,  v); chk("R13 hours", v, 8'd0);
    rd(8'd6,  v); chk("R13 dow", v, 8'd1);
    rd(8'd7,  v); chk("R13 dom", v, 8'd1);
    rd(8'd8,  v); chk("R13 month", v, 8'd1);
    rd(8'd9,  v); chk("R13 year", v, 8'd0);
    rd(8'd11, v); chk("R13 reg B", v, 8'h02);
    rd(8'd12, v); chk("R13 reg C", v, 8'h00);

    // R3 R4 R5 table of rollovers
    for (int k = 0; k < NV; k++) begin
      vec_t t;
      string tag;
      t = VECS[k];
      tag = t.h24 ? "R3/R4" : "R3/R5";
      load(t.h24 ? 8'h02 : 8'h00, t.s, t.m, t.h, t.dw, t.dm, t.mo, t.yr,
           8'hFF, 8'hFF, 8'hFF);
      wait_update(hp);
      rd(8'd0, v); chk(tag, v, t.es);
      rd(8'd2, v); chk(tag, v, t.em);
      rd(8'd4, v); chk(tag, v, t.eh);
      rd(8'd6, v); chk(tag, v, t.edw);
      rd(8'd7, v); chk(tag, v, t.edm);
      rd(8'd8, v); chk(tag, v, t.emo);
      rd(8'd9, v); chk(tag, v, t.eyr);
    end

    // R9 update flag only, no enables: irq stays high
    chk("R10 irq idle no enable", {7'd0, irq_n}, 8'd1);
    rd(8'd12, v); chk("R9 reg C UF only", v, 8'h10);

    // R6 lead and window length
    load(8'h02, 8'd10, 8'd0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'hFF, 8'hFF, 8'hFF);
    v = 8'h00;
    while (!v[7]) rd(8'd10, v);
    rd(8'd0, v); chk("R6 seconds before update", v, 8'd10);
    hp = 0;
    v = 8'h80;
    while (v[7] && hp < 200) begin rd(8'd10, v); hp++; end
    chk("R6 window polls in range", {7'd0, (hp >= 29 && hp <= 33)}, 8'd1);
    rd(8'd0, v); chk("R6 seconds after update", v, 8'd11);
    wr(8'd10, 8'hA0);
    rd(8'd10, v); chk("R6 bit7 write ignored", v, 8'h20);

    // R7 divider held
    wr(8'd10, 8'h60);
    rd(8'd0, v);
    repeat (300) @(posedge clk);
    rd(8'd10, v); chk("R7 reg A held, no UIP", v, 8'h60);
    rd(8'd0, v);  chk("R7 seconds frozen", v, 8'd11);
    wr(8'd10, 8'h20);

    // R8 update inhibit
    wr(8'd11, 8'h82);
    repeat (300) @(posedge clk);
    rd(8'd0, v);  chk("R8 seconds frozen", v, 8'd11);
    rd(8'd10, v); chk("R8 UIP reads 0", v, 8'h20);

    // R9 R10 R11 alarm with interrupt enable
    load(8'h22, 8'd30, 8'd20, 8'd10, 8'd1, 8'd1, 8'd1, 8'd1, 8'd31, 8'd20, 8'd10);
    wait_update(hp);
    @(negedge clk);
    chk("R10 irq low on alarm", {7'd0, irq_n}, 8'd0);
    rd(8'd12, v); chk("R9 reg C alarm", v, 8'hB0);
    @(negedge clk);
    chk("R11 irq released after read", {7'd0, irq_n}, 8'd1);
    rd(8'd12, v); chk("R11 reg C cleared", v, 8'h00);
    wr(8'd12, 8'hFF);
    rd(8'd12, v); chk("R11 write to C ignored", v, 8'h00);

    // R10 update interrupt enable
    load(8'h12, 8'd5, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd1, 8'hFF, 8'hFF, 8'hFF);
    wait_update(hp);
    @(negedge clk);
    chk("R10 irq low on update", {7'd0, irq_n}, 8'd0);
    rd(8'd12, v); chk("R10 reg C update", v, 8'h90);

    // R12
    wr(8'd13, 8'h00);
    rd(8'd13, v); chk("R12 reg D", v, 8'h80);

    // R1 R2 index latch and storage
    wr(8'd14, 8'h3C);
    wr(8'd63, 8'hC3);
    op(1'b0, 1'b1, 8'hC0 | 8'd40);
    op(1'b1, 1'b1, 8'h5A);
    rd(8'd14, v); chk("R2 ram low end", v, 8'h3C);
    rd(8'd63, v); chk("R2 ram high end", v, 8'hC3);
    rd(8'd40, v); chk("R1 index upper bits ignored", v, 8'h5A);
    op(1'b1, 1'b0, 8'h00); chk("R1 repeat read same index", rd_q, 8'h5A);
    op(1'b1, 1'b1, 8'h77);
    op(1'b1, 1'b0, 8'h00); chk("R1 data write keeps index", rd_q, 8'h77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule